// File: doc/BRIEF.md
# Fast Overrange Detector

This block raises an overrange status bit with as little delay as the signal chain allows. It watches two points of the converter's digital path and sets the flag from either one. The first path takes each sample leaving the first decimation stage, before any gain or offset correction. It forms that sample's magnitude and compares the top 16 bits with a programmable threshold. The second path watches the modulator itself. It counts how many modulator samples in a row exceed 100% of full scale, and sets the flag as soon as that run grows longer than four.

The threshold sits in a 16-bit register reached through a simple write port at address 5. It resets to 0xCCCC, which is 80% of the largest allowed input. The flag is read-only status. It clears only when a first-stage sample comes back at or under the threshold while the modulator run is no longer than four.

Top module: `ovr_fast_detect`

## Requirements
- R1: After reset the flag is 0, the run count is 0 and the threshold is 0xCCCC.
- R2: A write with `wr_addr` equal to 5 loads `wr_data` into the threshold. A write to any other address leaves the threshold unchanged.
- R3: A new threshold applies to first-stage samples from the cycle after the write. A sample presented in the same cycle as the write is compared with the old value.
- R4: The magnitude is the absolute value of the two's-complement sample, clamped to SAMPLE_W-1 bits so that the most negative code maps to all ones. The compared field is that magnitude's top 16 bits.
- R5: A first-stage sample whose field is strictly greater than the threshold sets the flag. A field equal to the threshold does not set it.
- R6: The flag is registered. It reflects a first-stage sample at the clock edge that accepts that sample.
- R7: At the clock edge that accepts the fifth consecutive modulator strobe with `mod_over_fs` high, the flag is set. Four consecutive such strobes do not set it.
- R8: A modulator strobe with `mod_over_fs` low returns the run count to zero.
- R9: The run count saturates above four. Runs of any length keep the flag set and never wrap.
- R10: The flag clears on a first-stage sample at or under the threshold when the run is four or shorter. Between first-stage samples, and while the run is longer than four, the flag holds.
- R11: Cycles without `mod_strobe` leave the run count unchanged, whatever `mod_over_fs` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s1_data | input | SAMPLE_W | First decimation stage output, two's complement |
| s1_valid | input | 1 | Strobe for `s1_data` |
| mod_strobe | input | 1 | One pulse per modulator sample |
| mod_over_fs | input | 1 | Current modulator sample is above 100% of full scale |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 16 | Register write data |
| ovr_flag | output | 1 | Overrange status bit |

## Verification
A threshold register that is off by a bit, or a magnitude that is wrong, shows up as a flag that differs on the very next first-stage sample near the threshold. So the sweep places samples exactly at, one step above and one step below each programmed threshold, on both signs. A run counter that counts one too many or too few, wraps, or misses a reset moves the flag's rising edge off the fifth strobe. It can also make the flag drop during a long run, and the first stage-one sample under the threshold after the run exposes it. Every cycle's flag is compared with an arithmetic model, so any such fault is caught within one cycle of the stimulus that exposes it.

// File: rtl/ovr_pkg.sv
package ovr_pkg;
  localparam int unsigned THR_W = 16;
  localparam logic [THR_W-1:0] THR_DEFAULT = 16'hCCCC;
  typedef logic [THR_W-1:0] thr_t;
endpackage

// File: rtl/ovr_rst_sync.sv
module ovr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_n;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ovr_thr_reg.sv
module ovr_thr_reg
  import ovr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned THR_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  thr_t              wr_data,
  output thr_t              thr_q
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(THR_ADDR);

  logic hit;
  thr_t thr_n;

  always_comb begin
    hit   = wr_en && (wr_addr == HIT_ADDR);
    thr_n = thr_q;
    if (hit) thr_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= THR_DEFAULT;
    else        thr_q <= thr_n;
  end

  // R2: addressed write lands, anything else holds the value
  p_thr_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (thr_q == $past(wr_data)));
  p_thr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(thr_q));
endmodule

// File: rtl/ovr_mag_cmp.sv
module ovr_mag_cmp
  import ovr_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s1_valid,
  input  logic [SAMPLE_W-1:0] s1_data,
  input  thr_t                thr,
  output logic                above
);
  localparam int unsigned MAG_W = SAMPLE_W - 1;
  localparam int unsigned LOW_W = MAG_W - THR_W;
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  logic [SAMPLE_W-1:0] mag_full;
  logic [MAG_W-1:0]    mag_sat;

  always_comb begin
    mag_full = s1_data[SAMPLE_W-1] ? (~s1_data + SAMPLE_W'(1)) : s1_data;
    mag_sat  = mag_full[SAMPLE_W-1] ? {MAG_W{1'b1}} : mag_full[MAG_W-1:0];
  end

  // Field > thr is the same as full magnitude > {thr, all ones below}
  generate
    if (LOW_W == 0) begin : g_exact
      assign above = (mag_sat > thr);
    end else begin : g_wide
      assign above = (mag_sat > {thr, {LOW_W{1'b1}}});
    end
  endgenerate

  // R4: most negative code clamps to full-scale magnitude
  p_most_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && (s1_data == MOST_NEG) && (thr != '1)) |-> above);
  // R5: a zero sample never exceeds any threshold
  p_zero_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && (s1_data == '0)) |-> !above);
endmodule

// File: rtl/ovr_run_cnt.sv
module ovr_run_cnt #(
  parameter int unsigned RUN_LIMIT = 4,
  localparam int unsigned CNT_W    = $clog2(RUN_LIMIT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_strobe,
  input  logic             mod_over_fs,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_gt_n
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(RUN_LIMIT);

  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (mod_strobe) begin
      if (!mod_over_fs)          cnt_n = '0;
      else if (cnt_q < CNT_MAX)  cnt_n = cnt_q + CNT_W'(1);
    end
    run_gt_n = (cnt_n > CNT_LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_strobe && !mod_over_fs) |=> (cnt_q == '0));
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_strobe && mod_over_fs && (cnt_q < CNT_MAX)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  p_cnt_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_strobe |=> $stable(cnt_q));
endmodule

// File: rtl/ovr_fast_detect.sv
module ovr_fast_detect
  import ovr_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 24,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned THR_ADDR  = 5,
  parameter int unsigned RUN_LIMIT = 4,
  localparam int unsigned CNT_W    = $clog2(RUN_LIMIT + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] s1_data,
  input  logic                s1_valid,
  input  logic                mod_strobe,
  input  logic                mod_over_fs,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [THR_W-1:0]    wr_data,
  output logic                ovr_flag
);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(RUN_LIMIT);

  logic             rst_n_i;
  thr_t             thr_q;
  logic             above;
  logic [CNT_W-1:0] cnt_q;
  logic             run_gt_n;
  logic             flag_q;
  logic             flag_n;

  ovr_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  ovr_thr_reg #(.ADDR_W(ADDR_W), .THR_ADDR(THR_ADDR)) i_thr_reg (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .thr_q   (thr_q)
  );

  ovr_mag_cmp #(.SAMPLE_W(SAMPLE_W)) i_mag_cmp (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .s1_valid (s1_valid),
    .s1_data  (s1_data),
    .thr      (thr_q),
    .above    (above)
  );

  ovr_run_cnt #(.RUN_LIMIT(RUN_LIMIT)) i_run_cnt (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .mod_strobe  (mod_strobe),
    .mod_over_fs (mod_over_fs),
    .cnt_q       (cnt_q),
    .run_gt_n    (run_gt_n)
  );

  always_comb begin
    flag_n = flag_q;
    if (s1_valid) flag_n = above;
    if (run_gt_n) flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) flag_q <= 1'b0;
    else          flag_q <= flag_n;
  end

  assign ovr_flag = flag_q;

  // R7/R9: a long run always shows at the flag
  p_run_flag_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cnt_q > CNT_LIM) |-> flag_q);
  // R5/R6: a sample above threshold sets the flag on the next edge
  p_above_sets_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (s1_valid && above) |=> flag_q);
  // R10: no stage-one sample, no clearing
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!s1_valid && flag_q) |=> flag_q);
endmodule

// File: tb/test_ovr_fast_detect.sv
module test_ovr_fast_detect;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 18;
  localparam int MAXMAG = (1 << (SW - 1)) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] s1_data = '0;
  logic          s1_valid = 1'b0;
  logic          mod_strobe = 1'b0;
  logic          mod_over_fs = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic          ovr_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] m_thr;
  int          m_cnt;
  logic        m_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovr_fast_detect #(.SAMPLE_W(SW)) i_ovr_fast_detect (
    .clk(clk), .rst_n(rst_n), .s1_data(s1_data), .s1_valid(s1_valid),
    .mod_strobe(mod_strobe), .mod_over_fs(mod_over_fs),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ovr_flag(ovr_flag)
  );

  function automatic logic exp_above(logic [SW-1:0] d, logic [15:0] t);
    int s = $signed(d);
    int m = (s < 0) ? -s : s;
    if (m > MAXMAG) m = MAXMAG;
    return ((m >> (SW - 1 - 16)) > int'(t));
  endfunction

  task automatic check(string tag);
    n_cmp++;
    if (ovr_flag !== m_flag) begin
      n_bad++;
      $display("FAIL %s: ovr_flag=%0b expected %0b at %0t", tag, ovr_flag, m_flag, $time);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare just after
  task automatic cyc(input logic v, input logic [SW-1:0] d, input logic st,
                     input logic ov, input logic w, input logic [3:0] a,
                     input logic [15:0] wd, input string tag);
    @(negedge clk);
    s1_valid = v; s1_data = d; mod_strobe = st; mod_over_fs = ov;
    wr_en = w; wr_addr = a; wr_data = wd;
    @(posedge clk);
    if (st) m_cnt = ov ? ((m_cnt < 5) ? m_cnt + 1 : 5) : 0;
    if (v) m_flag = exp_above(d, m_thr);
    if (m_cnt > 4) m_flag = 1'b1;
    if (w && a == 4'd5) m_thr = wd;
    #1;
    check(tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0, tag);
  endtask

  task automatic samp(input logic [SW-1:0] d, input string tag);
    cyc(1'b1, d, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0, tag);
  endtask

  task automatic mod(input logic ov, input string tag);
    cyc(1'b0, '0, 1'b1, ov, 1'b0, 4'd0, 16'h0, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] wd, input string tag);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1, a, wd, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] thr_list [6];
    thr_list[0] = 16'h0000; thr_list[1] = 16'h0001; thr_list[2] = 16'h8000;
    thr_list[3] = 16'hFFFE; thr_list[4] = 16'hFFFF; thr_list[5] = 16'h1234;
    m_thr = 16'hCCCC; m_cnt = 0; m_flag = 1'b0;

    repeat (3) @(posedge clk);
    #1; check("R1 flag in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1; check("R1 flag after reset");

    // R1/R5: default threshold 0xCCCC, equal does not set, one step above sets
    samp(SW'(32'h0CCCC << 1), "R1 R5 equal to default thr");
    samp(SW'((32'h0CCCC << 1) + 2), "R1 R5 one above default thr");
    samp(SW'(-((32'h0CCCC << 1) + 1)), "R4 R5 negative step");
    samp(SW'(32'h0CCCC << 1) + SW'(1), "R5 low bit below field");
    // R2: stray address ignored
    wr(4'd4, 16'h0000, "R2 write other address");
    samp(SW'(32'h0CCCC << 1), "R2 thr unchanged");
    // R3: sample in the write cycle uses the old threshold
    cyc(1'b1, SW'(32'h00100 << 1), 1'b0, 1'b0, 1'b1, 4'd5, 16'h00FF, "R3 same-cycle write");
    samp(SW'(32'h00100 << 1), "R3 new thr next sample");
    idle("R6 hold between samples");

    // R4/R5/R6 sweep over thresholds and sample patterns
    for (int t = 0; t < 6; t++) begin
      wr(4'd5, thr_list[t], "R2 program thr");
      for (int i = 0; i < 640; i++) begin
        int base = int'(thr_list[t]) * 2;
        logic [SW-1:0] d;
        case (i % 10)
          0: d = SW'(base);
          1: d = SW'(base + 2);
          2: d = SW'(-base);
          3: d = SW'(-(base + 2));
          4: d = {1'b1, {(SW-1){1'b0}}};
          5: d = SW'(MAXMAG);
          6: d = SW'(i * 2731);
          7: d = SW'(-(i * 977));
          8: d = SW'(base - 1);
          default: d = SW'(-(base + 1));
        endcase
        if (i % 37 == 0) wr(4'(i % 5), 16'h5A5A, "R2 stray writes");
        if (i % 13 == 0) mod(1'b1, "R8 short run in sweep");
        if (i % 13 == 1) mod(1'b0, "R8 run break in sweep");
        if (i % 7 == 0) idle("R10 hold between samples");
        samp(d, "R4 R5 R6 sweep");
      end
    end

    // modulator run path, threshold set to max so stage-one never sets
    wr(4'd5, 16'hFFFF, "R2 max thr");
    samp('0, "R10 clear before runs");
    for (int len = 0; len < 10; len++) begin
      for (int k = 0; k < len; k++) begin
        mod(1'b1, "R7 run strobe");
        cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0, "R11 idle keeps count");
        cyc(1'b0, '0, 1'b0, 1'b1, 1'b0, 4'd0, 16'h0, "R11 over without strobe");
      end
      samp('0, "R10 sample under thr after run");
      mod(1'b0, "R8 break run");
      samp('0, "R10 clear after break");
    end
    // R9: long run saturates, flag held through low samples
    for (int k = 0; k < 40; k++) begin
      mod(1'b1, "R9 long run");
      samp(SW'(5), "R9 R10 low sample during long run");
    end
    mod(1'b0, "R8 end long run");
    idle("R10 hold until stage-one sample");
    samp(SW'(5), "R10 clear after long run");
    // R8: four, break, four again must not set
    for (int k = 0; k < 4; k++) mod(1'b1, "R8 first four");
    mod(1'b0, "R8 break");
    for (int k = 0; k < 4; k++) mod(1'b1, "R8 second four");
    samp('0, "R7 R8 four is not enough");
    mod(1'b1, "R7 fifth sets");
    samp('0, "R10 hold while run above four");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule